// File: doc/BRIEF.md
# Two-Stage Multiply-Accumulate Unit

The unit takes a pair of unsigned 8-bit operands on each cycle that its input valid is high. It multiplies them in a registered first stage. In the second stage it adds the 16-bit product into a 20-bit running total. The second-stage adder is a carry-select adder built from uniform groups of 4 bits. Each group forms two candidate sums in parallel, one for an incoming carry of 0 and one for an incoming carry of 1. The real carry then picks one candidate per group, so the critical path runs through one short ripple adder and a chain of selectors, not through a full 20-bit ripple.

A synchronous clear empties the total and the overflow flag. A sticky overflow flag records any carry out of the top bit of the total. A one-cycle valid flag marks each cycle in which the total has just taken in a new product. The unit accepts one operand pair on every cycle, with no stalls.

Top module: `mac_csel`

## Requirements
- R1: Operands sampled with in_valid high at clock edge k reach the total at edge k+1. The updated total is visible on acc from edge k+1 onward.
- R2: Each accumulation sets acc to (acc + a*b) mod 2^20. The operands are unsigned and the adder uses 4-bit carry-select groups.
- R3: acc_valid is high for exactly the one cycle after each edge at which a product was added, and is low at all other times.
- R4: When clear is high at an edge, acc becomes 0 and overflow and acc_valid become 0 after that edge. This holds even if a product is waiting in the second stage, and that product is discarded.
- R5: At an edge where no product is waiting and clear is low, acc keeps its value.
- R6: overflow goes to 1 when an accumulation carries out of bit 19. It stays at 1 until clear or reset, and the total wraps.
- R7: While rst_n is low, at a clock edge acc, overflow, acc_valid and the product stage all become 0.
- R8: Operand pairs presented on consecutive cycles are all accumulated, at one pair per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on a and b is valid |
| a | input | 8 | Unsigned operand |
| b | input | 8 | Unsigned operand |
| clear | input | 1 | Synchronous clear of total and overflow flag |
| acc | output | 20 | Running total |
| acc_valid | output | 1 | Total updated at the last edge |
| overflow | output | 1 | Sticky carry out of the total |

## Verification
The hardest state to reach is overflow. With random 8-bit operands the total needs many dozens of products to pass 2^20. The flag and its stickiness are also hidden by any clear that lands along the way. A directed run therefore sends 17 back-to-back 255×255 products, which is the smallest count that crosses the limit. It then sends idle cycles and small products to show the flag stays set, and a clear to show it drops. Clear is also applied in the cycle when a product sits in the second stage, both with and without new input, so the case where the product is discarded gets exercised. A long random run, seeded and with sparse clears, then drives carries across every group boundary of the adder.

// File: rtl/mac_csel.sv
module mac_csel #(
  parameter int OPW  = 8,
  parameter int ACCW = 20,
  parameter int GRP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  input  logic            clear,
  output logic [ACCW-1:0] acc,
  output logic            acc_valid,
  output logic            overflow
);
  localparam int PW   = 2*OPW;
  localparam int NG   = (ACCW + GRP - 1) / GRP;
  localparam int PADW = NG * GRP;

  logic [PW-1:0]   prod_q;
  logic            prod_v;
  logic [ACCW-1:0] acc_q;
  logic            vld_q, ovf_q;

  logic [PADW-1:0] opx, opy, sum_pad;
  logic [NG:0]     cy;

  assign opx   = PADW'(acc_q);
  assign opy   = PADW'(prod_q);
  assign cy[0] = 1'b0;

  for (genvar g = 0; g < NG; g++) begin : g_csel
    logic [GRP:0] s0, s1;
    assign s0 = {1'b0, opx[g*GRP +: GRP]} + {1'b0, opy[g*GRP +: GRP]};
    assign s1 = {1'b0, opx[g*GRP +: GRP]} + {1'b0, opy[g*GRP +: GRP]} + (GRP+1)'(1);
    assign sum_pad[g*GRP +: GRP] = cy[g] ? s1[GRP-1:0] : s0[GRP-1:0];
    assign cy[g+1] = cy[g] ? s1[GRP] : s0[GRP];
  end

  logic [ACCW-1:0] sum_w;
  logic            cout_w;
  assign sum_w = sum_pad[ACCW-1:0];
  if (PADW == ACCW) begin : g_cout_full
    assign cout_w = cy[NG];
  end else begin : g_cout_pad
    assign cout_w = sum_pad[ACCW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      prod_v <= 1'b0;
    end else begin
      prod_q <= PW'(a) * PW'(b);
      prod_v <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= prod_v;
      if (prod_v) begin
        acc_q <= sum_w;
        ovf_q <= ovf_q | cout_w;
      end
    end
  end

  assign acc       = acc_q;
  assign acc_valid = vld_q;
  assign overflow  = ovf_q;

  assert_csel_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {cout_w, sum_w} == ({1'b0, acc_q} + (ACCW+1)'(prod_q)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0 && !overflow && !acc_valid));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !prod_v) |=> $stable(acc));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);
  assert_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && prod_v) |=> acc_valid);
endmodule

// File: tb/mac_csel_test.sv
`timescale 1ns/1ps
module mac_csel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic        clear = 1'b0;
  logic [19:0] acc;
  logic        acc_valid, overflow;

  int n_vec = 0, n_bad = 0;

  logic [15:0] m_p  = '0;
  logic        m_pv = 1'b0;
  logic [19:0] m_acc = '0;
  logic        m_vld = 1'b0, m_ovf = 1'b0;

  always #2 clk = ~clk;

  mac_csel uut (.clk, .rst_n, .in_valid, .a, .b, .clear, .acc, .acc_valid, .overflow);

  function automatic logic [20:0] add_ref(input logic [19:0] x, input logic [15:0] p);
    return {1'b0, x} + {5'b0, p};
  endfunction

  task automatic check(input string tag);
    n_vec++;
    if (acc !== m_acc || acc_valid !== m_vld || overflow !== m_ovf) begin
      n_bad++;
      $display("FAIL %s: acc=%0d vld=%0b ovf=%0b expected acc=%0d vld=%0b ovf=%0b",
               tag, acc, acc_valid, overflow, m_acc, m_vld, m_ovf);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] x, input logic [7:0] y,
                      input logic clr, input string tag);
    logic [20:0] s;
    @(negedge clk);
    in_valid = v; a = x; b = y; clear = clr;
    @(posedge clk);
    #1;
    if (clr) begin
      m_acc = '0; m_vld = 1'b0; m_ovf = 1'b0;
    end else begin
      m_vld = m_pv;
      if (m_pv) begin
        s = add_ref(m_acc, m_p);
        m_acc = s[19:0];
        m_ovf = m_ovf | s[20];
      end
    end
    m_p = 16'(x) * 16'(y);
    m_pv = v;
    check(tag);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: single product, latency
    step(1, 8'd3, 8'd7, 0, "R1 issue");
    step(0, 0, 0, 0, "R1 land");
    step(0, 0, 0, 0, "R5 idle hold");
    // R2: full-scale product
    step(1, 8'd255, 8'd255, 0, "R2 max");
    step(1, 8'd0, 8'd200, 0, "R2 zero operand");
    step(0, 0, 0, 0, "R3 valid pulse");
    step(0, 0, 0, 0, "R3 valid low");
    // R4: clear while product waiting in stage 2
    step(1, 8'd9, 8'd9, 0, "R4 preload");
    step(0, 0, 0, 1, "R4 clear drops waiting product");
    step(0, 0, 0, 0, "R4 after clear");
    // R4: clear together with new input
    step(1, 8'd10, 8'd10, 0, "R4 preload2");
    step(1, 8'd2, 8'd5, 1, "R4 clear with input");
    step(0, 0, 0, 0, "R4 new input survives");
    step(0, 0, 0, 1, "R4 clear");
    // R8 + R6: 17 back-to-back full-scale products
    for (int i = 0; i < 17; i++) step(1, 8'd255, 8'd255, 0, "R8 R6 stream");
    step(0, 0, 0, 0, "R6 overflow set");
    step(1, 8'd1, 8'd1, 0, "R6 sticky");
    step(0, 0, 0, 0, "R6 sticky2");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R5 hold");
    step(0, 0, 0, 1, "R6 R4 clear drops flag");
    step(0, 0, 0, 0, "R6 flag cleared");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic v, c;
      v = ($urandom % 4) != 0;
      c = ($urandom % 97) == 0;
      step(v, 8'($urandom), 8'($urandom), c, "R2 R3 R5 random");
    end

    // R7: reset mid-run
    step(1, 8'd200, 8'd100, 0, "R7 pre");
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk);
    #1;
    m_acc = '0; m_vld = 1'b0; m_ovf = 1'b0; m_pv = 1'b0; m_p = '0;
    check("R7 reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R7 stage empty after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule